// File: doc/BRIEF.md
# MFM Write Data Formatter

This block turns a serial bit stream into modified frequency modulation (MFM) write pulses for a disc write channel. A strobe marks the start of a sector. The block then lays down a zero-filled sync field by itself, so the read-side phase-locked loop has something to lock to. After the sync field it draws serial bits (the preamble first, then the data) from the serial output of a FIFO.

Timing comes from a clock enable at twice the bit rate. Each enable advances by one half-cell slot. The first slot of a cell is the clock slot and the second is the data slot. The encoded pulses pass through a short window. There, each pulse is compared with its nearest neighbours, and an early or late precompensation select is raised to counter pulse crowding on the medium.

When the FIFO has no bit ready at the moment a data bit is needed, the block encodes a zero and keeps an underflow flag raised until the next sector starts.

Top module: `mfm_write_formatter`

## Requirements
- R1: After reset, wr_pulse, pc_early, pc_late, fifo_ready and underflow are all 0. Until the first sector_start, half_en has no effect: no pulse appears and no bit is requested.
- R2: After sector_start the block emits 192 zero-bit cells (12 words of 16 bits) on its own. fifo_ready stays 0 throughout these cells.
- R3: Once the sync field is complete, fifo_ready is 1 in exactly those cycles where half_en is 1 at the clock slot (the first half) of a data cell. A bit is consumed when fifo_ready and fifo_valid are both 1.
- R4: MFM encoding works as follows. The data slot carries a pulse exactly when the cell's bit is 1. The clock slot carries a pulse exactly when both the cell's bit and the previous cell's bit are 0. The last sync bit counts as a 0 for the first data cell.
- R5: Each half_en advances the pulse stream by one slot. wr_pulse shows the slot that entered 4 half_en steps earlier, and shows 0 where no such slot exists since the last sector_start.
- R6: For a pulse on wr_pulse, let dn be the distance in slots to the nearest later pulse and dp the distance to the nearest earlier pulse. Each is counted within 4 slots, and 5 means none is found. pc_late is 1 when dn < dp, pc_early is 1 when dn > dp, and both are 0 otherwise or when wr_pulse is 0.
- R7: If fifo_ready is 1 while fifo_valid is 0, that cell is encoded as a 0 and underflow becomes 1. Underflow stays 1 until the next sector_start.
- R8: sector_start clears the pulse window, the previous-bit memory and underflow, then begins a new sync field. A half_en in the same cycle as sector_start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sector_start | input | 1 | One-cycle strobe that starts a sector write |
| half_en | input | 1 | Half-cell clock enable (twice the bit rate) |
| fifo_bit | input | 1 | Serial data bit from the FIFO |
| fifo_valid | input | 1 | FIFO has a bit available |
| fifo_ready | output | 1 | Request for the next data bit; a bit is taken when fifo_valid is also 1 |
| wr_pulse | output | 1 | Write pulse in the current half-cell slot |
| pc_early | output | 1 | Shift the current pulse early |
| pc_late | output | 1 | Shift the current pulse late |
| underflow | output | 1 | Sticky flag: a data bit was needed while the FIFO was empty |

## Verification
The sharpest overlap is a sector_start that lands in the same cycle as a half_en. The restart must win, and the enable must neither shift the window nor request a bit. The bench provokes this partway through a data stream that has already underflowed. It then checks that wr_pulse, underflow and fifo_ready all read 0 afterwards, and that the following slots match a fresh sync field from its first cell. Underflow is also made to coincide with the data-bit request: the cell is encoded as a zero and the flag appears at the next sample.

// File: rtl/mfm_fmt_pkg.sv
package mfm_fmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_DATA = 2'd2
    } fmt_state_e;

    typedef struct packed {
        logic cur_bit;
        logic prev_bit;
        logic underflow;
    } enc_regs_t;

endpackage

// File: rtl/mfm_sync_seq.sv
module mfm_sync_seq
    import mfm_fmt_pkg::*;
#(
    parameter int SYNC_CELLS = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic half_en,
    output logic active,
    output logic in_data,
    output logic phase
);
    localparam int CW = $clog2(SYNC_CELLS);

    typedef struct packed {
        fmt_state_e    state;
        logic          phase;
        logic [CW-1:0] cnt;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.state = ST_SYNC;
            r_d.phase = 1'b0;
            r_d.cnt   = '0;
        end else if (half_en && r_q.state != ST_IDLE) begin
            r_d.phase = ~r_q.phase;
            if (r_q.phase && r_q.state == ST_SYNC) begin
                if (r_q.cnt == CW'(SYNC_CELLS - 1)) begin
                    r_d.state = ST_DATA;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, phase: 1'b0, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign active  = (r_q.state != ST_IDLE);
    assign in_data = (r_q.state == ST_DATA);
    assign phase   = r_q.phase;

    // Data phase is entered only after the last sync cell
    assert_sync_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_data) |-> $past(r_q.cnt) == CW'(SYNC_CELLS - 1));

    // A restart always returns to the sync field at a clock slot
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!in_data && !phase && active));

    // Once in data phase it stays there until a restart
    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !start) |=> in_data);
endmodule

// File: rtl/mfm_cell_encoder.sv
module mfm_cell_encoder
    import mfm_fmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic step,
    input  logic phase,
    input  logic in_data,
    input  logic fifo_bit,
    input  logic fifo_valid,
    output logic fifo_ready,
    output logic slot_pulse,
    output logic underflow
);
    enc_regs_t r_q, r_d;
    logic      take_bit;
    logic      new_bit;

    always_comb begin
        r_d        = r_q;
        fifo_ready = step && !phase && in_data;
        take_bit   = fifo_ready && fifo_valid;
        new_bit    = take_bit ? fifo_bit : 1'b0;
        slot_pulse = 1'b0;
        if (start) begin
            r_d = '0;
        end else if (step) begin
            if (!phase) begin
                slot_pulse = !new_bit && !r_q.prev_bit;
                r_d.cur_bit = new_bit;
                if (fifo_ready && !fifo_valid) begin
                    r_d.underflow = 1'b1;
                end
            end else begin
                slot_pulse = r_q.cur_bit;
                r_d.prev_bit = r_q.cur_bit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign underflow = r_q.underflow;

    // A missing bit at request time raises the flag
    assert_uf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ready && !fifo_valid) |=> underflow);

    // The flag is sticky until a new sector
    assert_uf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !start) |=> underflow);

    // No bit is requested while the sync field runs
    assert_no_req_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_data |-> !fifo_ready);
endmodule

// File: rtl/mfm_precomp.sv
module mfm_precomp #(
    parameter int REACH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic step,
    input  logic slot_in,
    output logic wr_pulse,
    output logic pc_early,
    output logic pc_late
);
    localparam int WIN    = 2 * REACH + 1;
    localparam int CENTER = REACH;
    localparam int DW     = $clog2(REACH + 2);

    typedef struct packed {
        logic [WIN-1:0] win;
    } pc_regs_t;

    pc_regs_t       r_q, r_d;
    logic [DW-1:0]  dist_next;
    logic [DW-1:0]  dist_prev;

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.win = '0;
        end else if (step) begin
            r_d.win = {r_q.win[WIN-2:0], slot_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Nearest later pulse sits at lower indices, earlier pulse at higher ones
    always_comb begin
        dist_next = DW'(REACH + 1);
        dist_prev = DW'(REACH + 1);
        for (int i = REACH; i >= 1; i--) begin
            if (r_q.win[CENTER - i]) dist_next = DW'(i);
            if (r_q.win[CENTER + i]) dist_prev = DW'(i);
        end
    end

    assign wr_pulse = r_q.win[CENTER];
    assign pc_late  = wr_pulse && (dist_next < dist_prev);
    assign pc_early = wr_pulse && (dist_next > dist_prev);

    assert_one_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_early && pc_late));

    assert_shift_needs_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_early || pc_late) |-> wr_pulse);

    // Output only moves on an enable or a restart
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(step) && !$past(start) |-> $stable(wr_pulse));
endmodule

// File: rtl/mfm_write_formatter.sv
module mfm_write_formatter #(
    parameter int SYNC_WORDS = 12,
    parameter int WORD_BITS  = 16,
    parameter int PC_REACH   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sector_start,
    input  logic half_en,
    input  logic fifo_bit,
    input  logic fifo_valid,
    output logic fifo_ready,
    output logic wr_pulse,
    output logic pc_early,
    output logic pc_late,
    output logic underflow
);
    localparam int SYNC_CELLS = SYNC_WORDS * WORD_BITS;

    logic active;
    logic in_data;
    logic phase;
    logic step;
    logic slot_pulse;

    assign step = half_en && active && !sector_start;

    mfm_sync_seq #(.SYNC_CELLS(SYNC_CELLS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sector_start),
        .half_en (half_en),
        .active  (active),
        .in_data (in_data),
        .phase   (phase)
    );

    mfm_cell_encoder u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (sector_start),
        .step       (step),
        .phase      (phase),
        .in_data    (in_data),
        .fifo_bit   (fifo_bit),
        .fifo_valid (fifo_valid),
        .fifo_ready (fifo_ready),
        .slot_pulse (slot_pulse),
        .underflow  (underflow)
    );

    mfm_precomp #(.REACH(PC_REACH)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sector_start),
        .step     (step),
        .slot_in  (slot_pulse),
        .wr_pulse (wr_pulse),
        .pc_early (pc_early),
        .pc_late  (pc_late)
    );

    // Idle block never requests data
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!fifo_ready && !wr_pulse));
endmodule

// File: tb/mfm_write_formatter_bench.sv
module mfm_write_formatter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sector_start = 1'b0;
    logic half_en = 1'b0;
    logic fifo_bit = 1'b0;
    logic fifo_valid = 1'b0;
    logic fifo_ready, wr_pulse, pc_early, pc_late, underflow;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam int SYNC_HALVES = 12 * 16 * 2;
    localparam int NPAT = 12;
    localparam logic [7:0] PAT [NPAT] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80,
                                           8'hCC, 8'h33, 8'h0F, 8'hF0, 8'h49, 8'hB6};

    // Reference model state, built from the requirements
    logic [8:0] m_win = '0;
    logic m_prev = 1'b0, m_cur = 1'b0, m_phase = 1'b0, m_active = 1'b0, m_uf = 1'b0;
    int   m_cells = 0;

    always #5 clk = ~clk;

    mfm_write_formatter u_mfm_write_formatter (
        .clk(clk), .rst_n(rst_n), .sector_start(sector_start), .half_en(half_en),
        .fifo_bit(fifo_bit), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
        .wr_pulse(wr_pulse), .pc_early(pc_early), .pc_late(pc_late), .underflow(underflow)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int gap(input logic [8:0] w, input bit later);
        int d = 5;
        for (int k = 4; k >= 1; k--) begin
            if (later ? w[4-k] : w[4+k]) d = k;
        end
        return d;
    endfunction

    function automatic bit m_in_data();
        return m_active && (m_cells >= 192);
    endfunction

    task automatic check_outputs(input string tag);
        logic e_pulse, e_early, e_late;
        int dn, dp;
        e_pulse = m_win[4];
        dn = gap(m_win, 1'b1);
        dp = gap(m_win, 1'b0);
        e_late  = e_pulse && (dn < dp);
        e_early = e_pulse && (dn > dp);
        chk(wr_pulse == e_pulse, {tag, " R4 R5 wr_pulse"}, wr_pulse, e_pulse);
        chk(pc_late == e_late,   {tag, " R6 pc_late"}, pc_late, e_late);
        chk(pc_early == e_early, {tag, " R6 pc_early"}, pc_early, e_early);
        chk(underflow == m_uf,   {tag, " R7 underflow"}, underflow, m_uf);
    endtask

    task automatic model_restart();
        m_win = '0; m_prev = 1'b0; m_cur = 1'b0; m_phase = 1'b0;
        m_active = 1'b1; m_uf = 1'b0; m_cells = 0;
    endtask

    task automatic half_step(input logic b, input logic v, input string tag);
        logic e_ready, slot, nb;
        @(negedge clk);
        fifo_bit = b; fifo_valid = v; half_en = 1'b1;
        #1;
        e_ready = m_in_data() && !m_phase;
        chk(fifo_ready == e_ready, {tag, " R2 R3 fifo_ready"}, fifo_ready, e_ready);
        @(posedge clk);
        @(negedge clk);
        half_en = 1'b0;
        if (m_active) begin
            if (!m_phase) begin
                nb = (e_ready && v) ? b : 1'b0;
                if (e_ready && !v) m_uf = 1'b1;
                slot = !nb && !m_prev;
                m_cur = nb;
            end else begin
                slot = m_cur;
                m_prev = m_cur;
                m_cells++;
            end
            m_phase = !m_phase;
            m_win = {m_win[7:0], slot};
        end
        #1;
        check_outputs(tag);
    endtask

    task automatic run_sync();
        for (int i = 0; i < SYNC_HALVES; i++) half_step(1'b1, 1'b1, "sync");
    endtask

    task automatic send_byte(input logic [7:0] by, input string tag);
        for (int i = 7; i >= 0; i--) begin
            half_step(by[i], 1'b1, tag);
            half_step(by[i], 1'b1, tag);
        end
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(!wr_pulse && !pc_early && !pc_late, "R1 reset pulses", wr_pulse, 0);
        chk(!fifo_ready && !underflow, "R1 reset ready/underflow", fifo_ready, 0);
        // R1: half_en ignored while idle
        for (int i = 0; i < 6; i++) half_step(1'b1, 1'b1, "R1 idle");

        @(negedge clk); sector_start = 1'b1;
        @(negedge clk); sector_start = 1'b0; model_restart();
        #1;
        chk(!wr_pulse && !fifo_ready, "R8 after start", wr_pulse, 0);
        run_sync();

        // Vector table walk: data patterns (R3, R4, R6)
        for (int p = 0; p < NPAT; p++) send_byte(PAT[p], "table");

        // R7: underflow on the clock slot of a data cell
        half_step(1'b1, 1'b0, "R7 empty");
        half_step(1'b1, 1'b0, "R7 empty");
        send_byte(8'h6D, "R7 after");
        chk(underflow == 1'b1, "R7 sticky", underflow, 1);

        // R8: restart coincident with half_en
        @(negedge clk); sector_start = 1'b1; half_en = 1'b1; fifo_valid = 1'b1;
        @(negedge clk); sector_start = 1'b0; half_en = 1'b0; model_restart();
        #1;
        chk(wr_pulse == 1'b0, "R8 window cleared", wr_pulse, 0);
        chk(underflow == 1'b0, "R8 underflow cleared", underflow, 0);
        chk(fifo_ready == 1'b0, "R8 no request", fifo_ready, 0);
        run_sync();
        send_byte(8'h00, "R4 boundary");
        send_byte(8'hE7, "R6 mixed");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule